// File: doc/BRIEF.md
# Split-Transaction Request Table

This block sits between a cache's miss logic and a split-transaction system bus. A cache miss is entered into a small table. The table presents it on the bus request channel, and once the bus grants it the request is outstanding until a response carrying the same tag shows up on the separate response channel. The bus is free for other agents the whole time. Because the request and response channels are independent, an issue handshake and a response can both complete in the same cycle.

The table prevents a second request for a block that is already in flight, whether that request comes from this cache or from another agent seen on the bus. A local read miss to a block with a read already in the table is folded into that entry and shares its response. A local read-exclusive behind a pending read waits in a held entry and is sent on the bus only after the read has completed. A local request still waiting for the bus reacts to another agent's request for the same block. If both requests are reads, it adopts the other agent's response. Otherwise it backs off until that response has passed, then competes for the bus again.

Top module: `rt_req_table`

## Requirements
- R1: After reset the table is empty: `miss_ready` is 1, and `issue_valid` and `done_valid` are 0.
- R2: A miss accepted with no address match in the table takes the lowest free entry. From the next cycle it is offered on the issue port with its address and kind (`excl` 1 = read-exclusive, 0 = read) and the tag {`AGENT_ID`, entry index}. The lowest-indexed waiting entry is offered first, and an offer stays up until `issue_ready` is 1.
- R3: A response whose tag matches an issued entry raises `done_valid` in that same cycle with the entry's address and kind. The entry is free from the next cycle.
- R4: At most one request per block address is on the bus at a time. A read miss that matches a read entry is accepted without a new bus request, and that entry's completion shows `done_merged` = 1.
- R5: A read-exclusive miss that matches a read entry is accepted into a held entry. The held entry is not offered until the read completes, and is offered from the cycle after that completion.
- R6: A miss that matches a read-exclusive entry, or a read-exclusive miss to a block that already has a held entry, is refused (`miss_ready` = 0).
- R7: With every entry in use, a miss is refused unless it is a read that merges into an existing read entry.
- R8: A bus request from another agent (`snoop_valid`) that matches a waiting entry suppresses that entry's offer in the same cycle. If both requests are reads, the entry is never issued and completes with `done_valid` when a response carries the snooped tag.
- R9: If either the snooped request or the waiting entry is read-exclusive, the entry stays off the bus with no completion until a response carries the snooped tag. From the next cycle it is offered again.
- R10: An issue handshake and a response for a different entry in the same cycle are both carried out.
- R11: A miss that matches an entry completing in the current cycle is refused for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Local miss request present |
| miss_ready | output | 1 | Table accepts the miss this cycle |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_excl | input | 1 | 1 = read-exclusive, 0 = read |
| issue_valid | output | 1 | Request offered to the bus request channel |
| issue_ready | input | 1 | Bus grant for the offered request |
| issue_addr | output | ADDR_W | Offered block address |
| issue_excl | output | 1 | Offered request kind |
| issue_tag | output | TAG_W | Tag the response will carry |
| snoop_valid | input | 1 | Another agent's request is on the bus |
| snoop_addr | input | ADDR_W | Its block address |
| snoop_excl | input | 1 | Its kind |
| snoop_tag | input | TAG_W | Its response tag |
| resp_valid | input | 1 | Response present on the data channel |
| resp_tag | input | TAG_W | Response tag |
| done_valid | output | 1 | A table entry completes this cycle |
| done_addr | output | ADDR_W | Completed block address |
| done_excl | output | 1 | Completed request kind |
| done_merged | output | 1 | A merged read waiter shares this completion |

## Verification
The assertions check on every cycle that offered tags carry this agent's number and that no offer names the address of a simultaneous foreign request. They also check that completions occur only alongside a response, that merged completions are always reads, and that an unanswered offer persists unless a snoop intervenes. Merging, hold-and-reissue, the share and back-off reactions to snoops, the full-table stall and the same-cycle stall are sequences over several cycles, so only the bench scenarios show them. A randomized phase keeps a scoreboard of issued tags and checks that no block is issued twice while outstanding and that each completion reports the address its tag was issued with.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic [2:0] {
        ST_FREE  = 3'd0,  // slot unused
        ST_WAIT  = 3'd1,  // ready to be offered to the bus
        ST_PEND  = 3'd2,  // granted, waiting for its own response
        ST_HELD  = 3'd3,  // read-exclusive parked behind a read to the same block
        ST_SHARE = 3'd4,  // read adopting another agent's read response
        ST_DEFER = 3'd5   // backing off until another agent's response passes
    } ent_state_e;

endpackage

// File: rtl/rt_addr_match.sv
module rt_addr_match #(
    parameter int N = 4,
    parameter int W = 12
) (
    input  logic [N-1:0][W-1:0] tbl,
    input  logic [W-1:0]        key,
    input  logic [N-1:0]        en,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = en[g] && (tbl[g] == key);
    end
endmodule

// File: rtl/rt_prio_pick.sv
module rt_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/rt_req_table.sv
module rt_req_table
    import rt_pkg::*;
#(
    parameter int ENTRIES  = 4,
    parameter int ADDR_W   = 12,
    parameter int AGENT_W  = 2,
    parameter int AGENT_ID = 1,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int TAG_W   = AGENT_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              miss_excl,
    output logic              issue_valid,
    input  logic              issue_ready,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              issue_excl,
    output logic [TAG_W-1:0]  issue_tag,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              snoop_excl,
    input  logic [TAG_W-1:0]  snoop_tag,
    input  logic              resp_valid,
    input  logic [TAG_W-1:0]  resp_tag,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_addr,
    output logic              done_excl,
    output logic              done_merged
);

    typedef struct packed {
        ent_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              excl;
        logic [TAG_W-1:0]  tag;
        logic              merged;
    } ent_t;

    ent_t [ENTRIES-1:0] ent_d, ent_q;

    function automatic logic [TAG_W-1:0] own_tag(input int i);
        return {AGENT_W'(AGENT_ID), IDX_W'(i)};
    endfunction

    // ---------------- per-entry decode of the registered table ----------------
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [ENTRIES-1:0] live, held, rdent, waiting, resp_hit, fin;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_addr[i] = ent_q[i].addr;
            live[i]     = ent_q[i].st != ST_FREE;
            held[i]     = ent_q[i].st == ST_HELD;
            rdent[i]    = live[i] && !held[i] && !ent_q[i].excl;
            waiting[i]  = ent_q[i].st == ST_WAIT;
            resp_hit[i] = resp_valid && (ent_q[i].tag == resp_tag) &&
                          (ent_q[i].st == ST_PEND || ent_q[i].st == ST_SHARE ||
                           ent_q[i].st == ST_DEFER);
            fin[i]      = resp_hit[i] && (ent_q[i].st != ST_DEFER);
        end
    end

    // ---------------- address comparators ----------------
    logic [ENTRIES-1:0] miss_hit, snp_wait_hit, rel_hit_raw;

    rt_addr_match #(.N(ENTRIES), .W(ADDR_W)) u_miss_cmp (
        .tbl(ent_addr), .key(miss_addr), .en(live), .hit(miss_hit)
    );

    rt_addr_match #(.N(ENTRIES), .W(ADDR_W)) u_snp_cmp (
        .tbl(ent_addr), .key(snoop_addr), .en(waiting), .hit(snp_wait_hit)
    );

    rt_addr_match #(.N(ENTRIES), .W(ADDR_W)) u_rel_cmp (
        .tbl(ent_addr), .key(done_addr), .en(held), .hit(rel_hit_raw)
    );

    // ---------------- pickers ----------------
    logic [ENTRIES-1:0] iss_req;
    logic               free_any, fin_any;
    logic [IDX_W-1:0]   free_idx, iss_idx, fin_idx;

    assign iss_req = waiting & ~(snoop_valid ? snp_wait_hit : '0);

    rt_prio_pick #(.N(ENTRIES), .IW(IDX_W)) u_free_pick (
        .req(~live), .any(free_any), .idx(free_idx)
    );

    rt_prio_pick #(.N(ENTRIES), .IW(IDX_W)) u_iss_pick (
        .req(iss_req), .any(issue_valid), .idx(iss_idx)
    );

    rt_prio_pick #(.N(ENTRIES), .IW(IDX_W)) u_fin_pick (
        .req(fin), .any(fin_any), .idx(fin_idx)
    );

    // ---------------- outputs ----------------
    always_comb begin
        issue_addr  = ent_q[iss_idx].addr;
        issue_excl  = ent_q[iss_idx].excl;
        issue_tag   = own_tag(int'(iss_idx));
        done_valid  = fin_any;
        done_addr   = fin_any ? ent_q[fin_idx].addr   : '0;
        done_excl   = fin_any ? ent_q[fin_idx].excl   : 1'b0;
        done_merged = fin_any ? ent_q[fin_idx].merged : 1'b0;
    end

    // ---------------- miss acceptance decision ----------------
    logic [ENTRIES-1:0] merge_tgt, release_mask;
    logic merge_ok, hold_ok, plain_ok, tgt_busy, accept;

    always_comb begin
        merge_tgt    = miss_hit & rdent;
        merge_ok     = !miss_excl && (|merge_tgt);
        hold_ok      = miss_excl && (|merge_tgt) && !(|(miss_hit & held)) && free_any;
        plain_ok     = !(|miss_hit) && free_any;
        tgt_busy     = |(miss_hit & fin);
        miss_ready   = (merge_ok || hold_ok || plain_ok) && !tgt_busy;
        accept       = miss_valid && miss_ready;
        release_mask = rel_hit_raw & {ENTRIES{fin_any && !done_excl}};
    end

    // ---------------- next state ----------------
    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (resp_hit[i]) begin
                if (ent_q[i].st == ST_DEFER) begin
                    ent_d[i].st  = ST_WAIT;
                    ent_d[i].tag = own_tag(i);
                end else begin
                    ent_d[i].st     = ST_FREE;
                    ent_d[i].merged = 1'b0;
                end
            end
            if (release_mask[i]) ent_d[i].st = ST_WAIT;
            if (issue_valid && issue_ready && (iss_idx == IDX_W'(i))) ent_d[i].st = ST_PEND;
        end

        if (accept) begin
            if (merge_ok) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (merge_tgt[i]) ent_d[i].merged = 1'b1;
                end
            end else begin
                ent_d[free_idx].st     = hold_ok ? ST_HELD : ST_WAIT;
                ent_d[free_idx].addr   = miss_addr;
                ent_d[free_idx].excl   = miss_excl;
                ent_d[free_idx].tag    = own_tag(int'(free_idx));
                ent_d[free_idx].merged = 1'b0;
            end
        end

        if (snoop_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ent_d[i].st == ST_WAIT && ent_d[i].addr == snoop_addr) begin
                    ent_d[i].st  = (!snoop_excl && !ent_d[i].excl) ? ST_SHARE : ST_DEFER;
                    ent_d[i].tag = snoop_tag;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

endmodule

// File: rtl/rt_req_table_chk.sv
module rt_req_table_chk #(
    parameter int ENTRIES  = 4,
    parameter int ADDR_W   = 12,
    parameter int AGENT_W  = 2,
    parameter int AGENT_ID = 1,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int TAG_W   = AGENT_W + IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic              issue_ready,
    input logic [ADDR_W-1:0] issue_addr,
    input logic              issue_excl,
    input logic [TAG_W-1:0]  issue_tag,
    input logic              snoop_valid,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              resp_valid,
    input logic              done_valid,
    input logic              done_excl,
    input logic              done_merged
);
    // R2
    own_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> issue_tag[TAG_W-1 -: AGENT_W] == AGENT_W'(AGENT_ID));

    // R2
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_ready && !snoop_valid) |=> (issue_valid || snoop_valid));

    // R8
    snoop_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && snoop_valid) |-> (issue_addr != snoop_addr));

    // R3
    done_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> resp_valid);

    // R4
    merged_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_merged) |-> !done_excl);
endmodule

bind rt_req_table rt_req_table_chk #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .AGENT_W(AGENT_W), .AGENT_ID(AGENT_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_addr(issue_addr), .issue_excl(issue_excl), .issue_tag(issue_tag),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .resp_valid(resp_valid),
    .done_valid(done_valid), .done_excl(done_excl), .done_merged(done_merged)
);

// File: tb/rt_req_table_tb.sv
module rt_req_table_tb;
    localparam int AW = 12;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 0, miss_excl = 0, issue_ready = 0;
    logic snoop_valid = 0, snoop_excl = 0, resp_valid = 0;
    logic [AW-1:0] miss_addr = '0, snoop_addr = '0;
    logic [TW-1:0] snoop_tag = '0, resp_tag = '0;
    logic miss_ready, issue_valid, issue_excl, done_valid, done_excl, done_merged;
    logic [AW-1:0] issue_addr, done_addr;
    logic [TW-1:0] issue_tag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rt_req_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr), .miss_excl(miss_excl),
        .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_addr(issue_addr),
        .issue_excl(issue_excl), .issue_tag(issue_tag),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_excl(snoop_excl), .snoop_tag(snoop_tag),
        .resp_valid(resp_valid), .resp_tag(resp_tag),
        .done_valid(done_valid), .done_addr(done_addr), .done_excl(done_excl), .done_merged(done_merged)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // next cycle: wait for the falling edge and drop every single-cycle input
    task automatic nxt();
        @(negedge clk);
        miss_valid = 0; miss_excl = 0; issue_ready = 0;
        snoop_valid = 0; snoop_excl = 0; resp_valid = 0;
    endtask

    task automatic miss(input logic [AW-1:0] a, input logic x, input logic exp_rdy, input string req);
        nxt();
        miss_valid = 1; miss_addr = a; miss_excl = x;
        #1 chk(req, "miss_ready", miss_ready, exp_rdy);
    endtask

    task automatic grant(input logic [AW-1:0] a, input logic x, input string req, output logic [TW-1:0] t);
        nxt();
        issue_ready = 1;
        #1;
        chk(req, "issue_valid", issue_valid, 1);
        chk(req, "issue_addr", issue_addr, a);
        chk(req, "issue_excl", issue_excl, x);
        t = issue_tag;
    endtask

    task automatic respond(input logic [TW-1:0] t, input logic [AW-1:0] a, input logic x,
                           input logic m, input string req);
        nxt();
        resp_valid = 1; resp_tag = t;
        #1;
        chk(req, "done_valid", done_valid, 1);
        chk(req, "done_addr", done_addr, a);
        chk(req, "done_excl", done_excl, x);
        chk(req, "done_merged", done_merged, m);
    endtask

    task automatic expect_idle_issue(input string req);
        nxt();
        #1 chk(req, "issue_valid", issue_valid, 0);
    endtask

    // scoreboard for the randomized phase
    logic          out_v [16];
    logic [AW-1:0] out_a [16];

    function automatic bit addr_out(input logic [AW-1:0] a);
        for (int k = 0; k < 16; k++) if (out_v[k] && out_a[k] == a) return 1;
        return 0;
    endfunction

    function automatic int pick_out(input int start);
        for (int k = 0; k < 16; k++) if (out_v[(start + k) % 16]) return (start + k) % 16;
        return -1;
    endfunction

    task automatic rand_cycle(input bit drain);
        int p;
        nxt();
        if (!drain) begin
            miss_valid = $urandom % 2;
            miss_addr  = 12'h0A0 + AW'($urandom % 8);
            miss_excl  = ($urandom % 4) == 0;
        end
        issue_ready = drain ? 1'b1 : 1'($urandom % 2);
        p = pick_out(int'($urandom % 16));
        if (p >= 0 && (drain || ($urandom % 3) == 0)) begin
            resp_valid = 1; resp_tag = TW'(p);
        end
        #1;
        if (issue_valid && issue_ready) begin
            chk("R4", "issued tag already outstanding", out_v[issue_tag], 0);
            chk("R4", "issued block already outstanding", addr_out(issue_addr), 0);
        end
        if (resp_valid) begin
            chk("R3", "random done_valid", done_valid, 1);
            chk("R3", "random done_addr", done_addr, out_a[resp_tag]);
            out_v[resp_tag] = 0;
        end
        if (issue_valid && issue_ready) begin
            out_v[issue_tag] = 1;
            out_a[issue_tag] = issue_addr;
        end
    endtask

    initial begin
        logic [TW-1:0] t, t1, t2, t3;
        logic [TW-1:0] tf [4];
        void'($urandom(32'h5eed_0042));
        for (int k = 0; k < 16; k++) begin out_v[k] = 0; out_a[k] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "miss_ready after reset", miss_ready, 1);
        chk("R1", "issue_valid after reset", issue_valid, 0);
        chk("R1", "done_valid after reset", done_valid, 0);

        // R2/R3: single read, offer held while not granted
        miss(12'h010, 0, 1, "R2");
        nxt(); #1;
        chk("R2", "issue_valid", issue_valid, 1);
        chk("R2", "issue_tag", issue_tag, 4'h4);
        grant(12'h010, 0, "R2", t);
        expect_idle_issue("R2");
        respond(t, 12'h010, 0, 0, "R3");
        nxt(); #1 chk("R3", "done clears", done_valid, 0);

        // R4: read merge
        miss(12'h020, 0, 1, "R4");
        grant(12'h020, 0, "R4", t);
        miss(12'h020, 0, 1, "R4");
        expect_idle_issue("R4");
        respond(t, 12'h020, 0, 1, "R4");

        // R5: read-exclusive held behind a read
        miss(12'h030, 0, 1, "R5");
        grant(12'h030, 0, "R5", t);
        miss(12'h030, 1, 1, "R5");
        expect_idle_issue("R5");
        respond(t, 12'h030, 0, 0, "R5");
        chk("R5", "held not offered before completion", issue_valid, 0);
        grant(12'h030, 1, "R5", t2);
        respond(t2, 12'h030, 1, 0, "R5");

        // R6: stalls on exclusive entries and on a second held request
        miss(12'h040, 1, 1, "R6");
        grant(12'h040, 1, "R6", t);
        miss(12'h040, 0, 0, "R6");
        miss(12'h040, 1, 0, "R6");
        respond(t, 12'h040, 1, 0, "R6");
        miss(12'h041, 0, 1, "R6");
        grant(12'h041, 0, "R6", t);
        miss(12'h041, 1, 1, "R6");
        miss(12'h041, 1, 0, "R6");
        respond(t, 12'h041, 0, 0, "R6");
        grant(12'h041, 1, "R6", t2);
        respond(t2, 12'h041, 1, 0, "R6");

        // R7: full table
        for (int k = 0; k < 4; k++) miss(12'h050 + AW'(k), 0, 1, "R7");
        miss(12'h060, 0, 0, "R7");
        miss(12'h050, 0, 1, "R7");
        for (int k = 0; k < 4; k++) begin
            grant(12'h050 + AW'(k), 0, "R2", t3);
            tf[k] = t3;
        end
        for (int k = 3; k >= 0; k--) respond(tf[k], 12'h050 + AW'(k), 0, (k == 0), "R7");

        // R8: foreign read adopted
        miss(12'h070, 0, 1, "R8");
        nxt();
        snoop_valid = 1; snoop_addr = 12'h070; snoop_excl = 0; snoop_tag = 4'h9;
        #1 chk("R8", "offer suppressed under snoop", issue_valid, 0);
        expect_idle_issue("R8");
        respond(4'h9, 12'h070, 0, 0, "R8");
        expect_idle_issue("R8");

        // R9: back-off on foreign exclusive, then reissue
        miss(12'h080, 0, 1, "R9");
        nxt();
        snoop_valid = 1; snoop_addr = 12'h080; snoop_excl = 1; snoop_tag = 4'hA;
        #1 chk("R9", "offer suppressed under snoop", issue_valid, 0);
        expect_idle_issue("R9");
        nxt();
        resp_valid = 1; resp_tag = 4'hA;
        #1 chk("R9", "no completion on foreign response", done_valid, 0);
        grant(12'h080, 0, "R9", t);
        respond(t, 12'h080, 0, 0, "R9");
        // snoop in the same cycle as the miss
        nxt();
        miss_valid = 1; miss_addr = 12'h088; miss_excl = 1;
        snoop_valid = 1; snoop_addr = 12'h088; snoop_excl = 0; snoop_tag = 4'hB;
        #1 chk("R9", "miss_ready", miss_ready, 1);
        expect_idle_issue("R9");
        nxt();
        resp_valid = 1; resp_tag = 4'hB;
        #1 chk("R9", "no completion on foreign response", done_valid, 0);
        grant(12'h088, 1, "R9", t);
        respond(t, 12'h088, 1, 0, "R9");

        // R10: grant and response in one cycle
        miss(12'h090, 0, 1, "R10");
        grant(12'h090, 0, "R10", t1);
        miss(12'h091, 0, 1, "R10");
        nxt();
        issue_ready = 1; resp_valid = 1; resp_tag = t1;
        #1;
        chk("R10", "done_valid", done_valid, 1);
        chk("R10", "done_addr", done_addr, 12'h090);
        chk("R10", "issue_valid", issue_valid, 1);
        chk("R10", "issue_addr", issue_addr, 12'h091);
        t2 = issue_tag;
        nxt(); #1;
        chk("R10", "issue taken", issue_valid, 0);
        chk("R10", "done cleared", done_valid, 0);
        respond(t2, 12'h091, 0, 0, "R10");

        // R11: miss against an entry completing now
        miss(12'h098, 0, 1, "R11");
        grant(12'h098, 0, "R11", t);
        nxt();
        resp_valid = 1; resp_tag = t;
        miss_valid = 1; miss_addr = 12'h098; miss_excl = 0;
        #1;
        chk("R11", "miss_ready", miss_ready, 0);
        chk("R11", "done_valid", done_valid, 1);
        miss(12'h098, 0, 1, "R11");
        grant(12'h098, 0, "R11", t);
        respond(t, 12'h098, 0, 0, "R11");

        // randomized traffic with scoreboard
        for (int n = 0; n < 400; n++) rand_cycle(0);
        for (int n = 0; n < 80; n++) rand_cycle(1);
        nxt(); #1;
        chk("R4", "nothing left outstanding", pick_out(0), 32'hFFFF_FFFF);
        chk("R2", "no offer after drain", issue_valid, 0);
        chk("R1", "table accepts after drain", miss_ready, 1);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule